// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory tree of descriptors. A request carries the virtual address, a root pointer to the context table, a context number, a write flag and the translation-enable flag. The walker reads one 32-bit descriptor per level through a single memory port with a valid/ready handshake. It stops when it meets a page table entry (PTE) or a descriptor that ends the walk in a fault.

A successful walk returns the PTE, the width of the page offset and the physical address. When the PTE's referenced bit is clear, or when the access is a write and the modified bit is clear, the walker first writes the updated PTE back to the address it was read from. With translation disabled the walker answers in one cycle with the virtual address as the physical address, grants full permission, and touches no memory. The permission check, any TLB and trap generation belong to the caller.

Top module: `ptw_walker`

## Requirements
- R1: With `mmuEnable` low, a start produces `done` on the next cycle with `physAddr` equal to the zero-extended `vaddr`, `fullPerm` high, `fault` low, and no memory request.
- R2: The first descriptor is read from `ctxTablePtr*16 + ctxNum*4`.
- R3: Descriptor type is bits [1:0]: 0 invalid, 1 pointer, 2 PTE, 3 reserved. A pointer's next table base is `{desc[31:2],2'b00}*16`. The table indices are VA[31:24] (first table), VA[23:18] (second) and VA[17:12] (third), each times 4.
- R4: A PTE in the first, second or third table ends the walk with `offWidth` 24, 18 or 12 and `physAddr = {pte[31:8],12'h000} + VA[offWidth-1:0]`. `pteOut` holds the PTE with any bit updates applied.
- R5: An invalid descriptor ends the walk with `fault` high and `faultCode = level*256 + 1*4`. The level is 0 for the context entry and 1, 2 or 3 for the tables.
- R6: A reserved descriptor, a PTE in the context entry, or a pointer in the third table ends the walk with `faultCode = level*256 + 4*4`.
- R7: A found PTE with referenced bit 5 clear, or a write with modified bit 6 clear, is written back to its own address with bit 5 set and, on a write, bit 6 set. This happens before `done`.
- R8: When bit 5 is already set, and on a write bit 6 is also set, no memory write occurs.
- R9: `busy` is high from the cycle after an accepted start until `done`. A start while `busy` is ignored and does not change the result of the walk in progress.
- R10: A synchronous reset returns the walker to idle and clears `busy`, `done`, `fault` and `memReqValid`.
- R11: Once `memReqValid` is raised it stays high, with address and write flag stable, until `memReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start a walk (taken only when idle) |
| mmuEnable | input | 1 | Translation enable; low selects pass-through |
| isWrite | input | 1 | Access is a write |
| vaddr | input | 32 | Virtual address |
| ctxTablePtr | input | 28 | Context table pointer (byte address / 16) |
| ctxNum | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk ended in a fault |
| faultCode | output | 10 | Level in [9:8], fault type in [4:2] |
| pteOut | output | 32 | PTE that ended the walk |
| offWidth | output | 5 | Page offset width (24, 18, 12; 0 otherwise) |
| physAddr | output | 36 | Physical address |
| fullPerm | output | 1 | Pass-through result with all permissions |
| memReqValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memReady | input | 1 | Memory accepts request / read data valid |
| memRdata | input | 32 | Memory read data |

## Verification
Walks are run to each of the three page sizes, so that a wrong index field or offset mask shows up as a different physical address. They are also run into faults at every level, with invalid, reserved, early-PTE and late-pointer descriptors, which tells the level bits apart from the type bits. PTEs with the reference and modify bits in each combination, under reads and writes, separate a needed write-back from a needless one. Varying memory latency, a start while busy and a mid-walk reset expose handshake and sequencing errors. The read-address log shows the first descriptor address and each table index.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W = 32;
  localparam int PA_W = 36;
  localparam int ROOT_W = 28;
  localparam int CODE_W = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {
    DT_INV = 2'd0,
    DT_PTR = 2'd1,
    DT_PTE = 2'd2,
    DT_RSV = 2'd3
  } descType_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBACK,
    ST_FINISH
  } walkState_t;

  typedef struct packed {
    logic ldStart;
    logic ldNext;
    logic ldPte;
    logic finOk;
    logic finFault;
    logic faultRsv;
    logic finBypass;
  } ptwStrobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       mmuEnable,
  input  logic       memReady,
  input  logic [1:0] descBits,
  input  logic [1:0] lvl,
  input  logic       wbNeedNow,
  output ptwStrobe_t stb,
  output logic       memReqValid,
  output logic       memWrite,
  output logic       busy
);
  walkState_t state, stateNext;
  descType_t  dType;
  logic       atCtx, atLast;

  assign dType  = descType_t'(descBits);
  assign atCtx  = (lvl == 2'd0);
  assign atLast = (lvl == 2'd3);

  always_comb begin
    stb         = '0;
    stateNext   = state;
    memReqValid = 1'b0;
    memWrite    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (!mmuEnable) begin
            stb.finBypass = 1'b1;
          end else begin
            stb.ldStart = 1'b1;
            stateNext   = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        memReqValid = 1'b1;
        if (memReady) begin
          if (dType == DT_PTR && !atLast) begin
            stb.ldNext = 1'b1;
          end else if (dType == DT_PTE && !atCtx) begin
            stb.ldPte = 1'b1;
            stateNext = wbNeedNow ? ST_WBACK : ST_FINISH;
          end else begin
            stb.finFault = 1'b1;
            stb.faultRsv = (dType != DT_INV);
            stateNext    = ST_IDLE;
          end
        end
      end
      ST_WBACK: begin
        memReqValid = 1'b1;
        memWrite    = 1'b1;
        if (memReady) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        stb.finOk = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq));
  assert_write_only_in_wb_R7: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> memReqValid && busy);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ptwStrobe_t        stb,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              isWrite,
  input  logic [ROOT_W-1:0] ctxTablePtr,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [31:0]       memRdata,
  output logic [1:0]        lvl,
  output logic              wbNeedNow,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic              done,
  output logic              fault,
  output logic [CODE_W-1:0] faultCode,
  output logic [31:0]       pteOut,
  output logic [4:0]        offWidth,
  output logic [PA_W-1:0]   physAddr,
  output logic              fullPerm
);
  localparam int PAD_W = 32 - CTX_W - 2;

  logic [31:0]     addrReg, vaReg, pteReg;
  logic            isWrReg;
  logic [31:0]     ctxAddr, nextBase, nextIdx, pteUpd;
  logic [31:0]     lvlOff [4];
  logic [4:0]      lvlW   [4];
  logic [PA_W-1:0] frameBase;

  assign ctxAddr  = {ctxTablePtr, 4'h0} + {{PAD_W{1'b0}}, ctxNum, 2'b00};
  assign nextBase = {memRdata[27:2], 6'b0};

  always_comb begin
    unique case (lvl)
      2'd0:    nextIdx = {22'b0, vaReg[31:24], 2'b00};
      2'd1:    nextIdx = {24'b0, vaReg[23:18], 2'b00};
      default: nextIdx = {24'b0, vaReg[17:12], 2'b00};
    endcase
  end

  assign pteUpd    = memRdata | (32'd1 << REF_BIT) | (isWrReg ? (32'd1 << MOD_BIT) : 32'd0);
  assign wbNeedNow = (pteUpd != memRdata);

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    if (g == 0) begin : g_none
      assign lvlOff[g] = '0;
      assign lvlW[g]   = '0;
    end else begin : g_page
      localparam int OW = 30 - 6 * g;
      assign lvlOff[g] = {{(32 - OW){1'b0}}, vaReg[OW-1:0]};
      assign lvlW[g]   = 5'(OW);
    end
  end

  assign frameBase = {pteReg[31:8], 12'h000};

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0; vaReg <= '0; pteReg <= '0; isWrReg <= 1'b0; lvl <= '0;
      done <= 1'b0; fault <= 1'b0; faultCode <= '0; pteOut <= '0;
      offWidth <= '0; physAddr <= '0; fullPerm <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.ldStart) begin
        vaReg   <= vaddr;
        isWrReg <= isWrite;
        addrReg <= ctxAddr;
        lvl     <= 2'd0;
        fault   <= 1'b0;
      end
      if (stb.ldNext) begin
        addrReg <= nextBase + nextIdx;
        lvl     <= lvl + 2'd1;
      end
      if (stb.ldPte) pteReg <= pteUpd;
      if (stb.finOk) begin
        done     <= 1'b1;
        fault    <= 1'b0;
        fullPerm <= 1'b0;
        pteOut   <= pteReg;
        offWidth <= lvlW[lvl];
        physAddr <= frameBase + {{(PA_W - 32){1'b0}}, lvlOff[lvl]};
      end
      if (stb.finFault) begin
        done      <= 1'b1;
        fault     <= 1'b1;
        fullPerm  <= 1'b0;
        faultCode <= {lvl, 3'b000, (stb.faultRsv ? 3'd4 : 3'd1), 2'b00};
        pteOut    <= '0;
        offWidth  <= '0;
        physAddr  <= '0;
      end
      if (stb.finBypass) begin
        done     <= 1'b1;
        fault    <= 1'b0;
        fullPerm <= 1'b1;
        pteOut   <= '0;
        offWidth <= '0;
        physAddr <= {{(PA_W - VA_W){1'b0}}, vaddr};
      end
    end
  end

  assign memAddr  = addrReg;
  assign memWdata = pteReg;

  assert_fault_code_shape_R5: assert property (@(posedge clk) disable iff (rst)
    fault |-> (faultCode[7:5] == 3'b0) && (faultCode[1:0] == 2'b0) &&
              ((faultCode[4:2] == 3'd1) || (faultCode[4:2] == 3'd4)));
  assert_page_width_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && !fullPerm) |->
      (offWidth == 5'd12 || offWidth == 5'd18 || offWidth == 5'd24));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              mmuEnable,
  input  logic              isWrite,
  input  logic [31:0]       vaddr,
  input  logic [27:0]       ctxTablePtr,
  input  logic [CTX_W-1:0]  ctxNum,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [9:0]        faultCode,
  output logic [31:0]       pteOut,
  output logic [4:0]        offWidth,
  output logic [35:0]       physAddr,
  output logic              fullPerm,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic              memReady,
  input  logic [31:0]       memRdata
);
  ptwStrobe_t stb;
  logic [1:0] lvl;
  logic       wbNeedNow;

  ptw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .mmuEnable(mmuEnable),
    .memReady(memReady), .descBits(memRdata[1:0]), .lvl(lvl),
    .wbNeedNow(wbNeedNow), .stb(stb), .memReqValid(memReqValid),
    .memWrite(memWrite), .busy(busy)
  );

  ptw_dpath #(.CTX_W(CTX_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .vaddr(vaddr), .isWrite(isWrite),
    .ctxTablePtr(ctxTablePtr), .ctxNum(ctxNum), .memRdata(memRdata),
    .lvl(lvl), .wbNeedNow(wbNeedNow), .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .fault(fault), .faultCode(faultCode), .pteOut(pteOut),
    .offWidth(offWidth), .physAddr(physAddr), .fullPerm(fullPerm)
  );

  assert_bypass_no_mem_R1: assert property (@(posedge clk) disable iff (rst)
    (startReq && !busy && !mmuEnable) |=> done && fullPerm && !memReqValid);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (memReqValid && !memReady) |=> memReqValid && $stable(memAddr) && $stable(memWrite));
  assert_wb_marks_ref_R7: assert property (@(posedge clk) disable iff (rst)
    (memReqValid && memWrite) |-> memWdata[5] && (memWdata[1:0] == 2'd2));
  assert_done_leaves_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0, mmuEnable = 1'b0, isWrite = 1'b0;
  logic [31:0] vaddr = '0;
  logic [27:0] ctxTablePtr = 28'h4;
  logic [7:0]  ctxNum = 8'd1;
  logic        busy, done, fault, fullPerm, memReqValid, memWrite;
  logic [9:0]  faultCode;
  logic [31:0] pteOut, memAddr, memWdata, memRdata;
  logic [4:0]  offWidth;
  logic [35:0] physAddr;
  logic        memReady;

  int checks = 0, failures = 0;
  int memLat = 0;
  int lat = 0;
  int rdCount = 0, wrCount = 0;
  logic [31:0] rdLog [16];
  logic [31:0] lastWrAddr, lastWrData;
  logic [31:0] mem [256];

  always #5 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .mmuEnable(mmuEnable),
    .isWrite(isWrite), .vaddr(vaddr), .ctxTablePtr(ctxTablePtr), .ctxNum(ctxNum),
    .busy(busy), .done(done), .fault(fault), .faultCode(faultCode),
    .pteOut(pteOut), .offWidth(offWidth), .physAddr(physAddr), .fullPerm(fullPerm),
    .memReqValid(memReqValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (rst) begin
      memReady <= 1'b0;
      lat      <= 0;
    end else if (memReady) begin
      memReady <= 1'b0;
      if (memWrite) begin
        wrCount    <= wrCount + 1;
        lastWrAddr <= memAddr;
        lastWrData <= memWdata;
      end else begin
        rdLog[rdCount % 16] <= memAddr;
        rdCount <= rdCount + 1;
      end
    end else if (memReqValid) begin
      if (lat >= memLat) begin
        memReady <= 1'b1;
        lat      <= 0;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setupTables(input logic [31:0] pte4k);
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[32'h044 >> 2] = 32'h0000_0011;
    mem[32'h04C >> 2] = 32'h0000_0002;
    mem[32'h104 >> 2] = 32'h0000_0021;
    mem[32'h108 >> 2] = 32'h0040_0062;
    mem[32'h204 >> 2] = 32'h0000_0031;
    mem[32'h208 >> 2] = 32'h0005_0022;
    mem[32'h20C >> 2] = 32'h0000_0003;
    mem[32'h314 >> 2] = pte4k;
    mem[32'h318 >> 2] = 32'h0000_0001;
  endtask

  task automatic walk(input logic [31:0] va, input logic [7:0] ctx, input logic en, input logic wr);
    int n = 0;
    @(negedge clk);
    vaddr = va; ctxNum = ctx; mmuEnable = en; isWrite = wr; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("walk timeout", 0, 1);
  endtask

  task automatic tReset();
    chk("R10 busy after reset", busy, 0);
    chk("R10 done after reset", done, 0);
    chk("R10 fault after reset", fault, 0);
    chk("R10 memReqValid after reset", memReqValid, 0);
  endtask

  task automatic tBypass();
    int r0 = rdCount;
    int w0 = wrCount;
    walk(32'hDEAD_BEEF, 8'd1, 1'b0, 1'b1);
    chk("R1 pa", physAddr, 36'h0_DEAD_BEEF);
    chk("R1 fullPerm", fullPerm, 1);
    chk("R1 fault", fault, 0);
    chk("R1 no mem traffic", (rdCount - r0) + (wrCount - w0), 0);
  endtask

  task automatic t4kRead();
    int r0, w0;
    setupTables(32'h0012_3402);
    memLat = 0;
    r0 = rdCount; w0 = wrCount;
    walk(32'h0104_5ABC, 8'd1, 1'b1, 1'b0);
    chk("R2 first read addr", rdLog[r0 % 16], 32'h044);
    chk("R3 L1 read addr", rdLog[(r0 + 1) % 16], 32'h104);
    chk("R3 L2 read addr", rdLog[(r0 + 2) % 16], 32'h204);
    chk("R3 L3 read addr", rdLog[(r0 + 3) % 16], 32'h314);
    chk("R4 4K pa", physAddr, 36'h0_0123_4ABC);
    chk("R4 4K offWidth", offWidth, 12);
    chk("R4 fault", fault, 0);
    chk("R7 pteOut ref set", pteOut, 32'h0012_3422);
    chk("R7 one writeback", wrCount - w0, 1);
    chk("R7 wb addr", lastWrAddr, 32'h314);
    chk("R7 wb data", lastWrData, 32'h0012_3422);
  endtask

  task automatic t4kWriteMod();
    int w0;
    setupTables(32'h0012_3422);
    memLat = 2;
    w0 = wrCount;
    walk(32'h0104_5ABC, 8'd1, 1'b1, 1'b1);
    chk("R7 write sets mod wb count", wrCount - w0, 1);
    chk("R7 write sets mod data", lastWrData, 32'h0012_3462);
    chk("R7 pteOut mod", pteOut, 32'h0012_3462);
  endtask

  task automatic tNoWb();
    int w0;
    setupTables(32'h0012_3462);
    memLat = 1;
    w0 = wrCount;
    walk(32'h0104_5ABC, 8'd1, 1'b1, 1'b1);
    chk("R8 no wb on write with R,M set", wrCount - w0, 0);
    chk("R8 pteOut unchanged", pteOut, 32'h0012_3462);
    w0 = wrCount;
    walk(32'h0108_1234, 8'd1, 1'b1, 1'b0);
    chk("R8 no wb on read with R set, M clear", wrCount - w0, 0);
  endtask

  task automatic tBigPages();
    setupTables(32'h0012_3402);
    memLat = 3;
    walk(32'h02AB_CDEF, 8'd1, 1'b1, 1'b0);
    chk("R4 16M pa", physAddr, 36'h0_04AB_CDEF);
    chk("R4 16M offWidth", offWidth, 24);
    chk("R4 16M pteOut", pteOut, 32'h0040_0062);
    memLat = 0;
    walk(32'h0108_1234, 8'd1, 1'b1, 1'b0);
    chk("R4 256K pa", physAddr, 36'h0_0050_1234);
    chk("R4 256K offWidth", offWidth, 18);
  endtask

  task automatic tFaults();
    setupTables(32'h0012_3402);
    memLat = 1;
    walk(32'h0104_5ABC, 8'd2, 1'b1, 1'b0);
    chk("R5 ctx invalid fault", fault, 1);
    chk("R5 ctx invalid code", faultCode, 10'h004);
    walk(32'h0104_5ABC, 8'd3, 1'b1, 1'b0);
    chk("R6 ctx PTE code", faultCode, 10'h010);
    walk(32'h0300_0000, 8'd1, 1'b1, 1'b0);
    chk("R5 L1 invalid code", faultCode, 10'h104);
    walk(32'h010C_0000, 8'd1, 1'b1, 1'b0);
    chk("R6 L2 reserved code", faultCode, 10'h210);
    walk(32'h0104_6000, 8'd1, 1'b1, 1'b0);
    chk("R6 L3 pointer code", faultCode, 10'h310);
    walk(32'h0104_7000, 8'd1, 1'b1, 1'b0);
    chk("R5 L3 invalid code", faultCode, 10'h304);
    chk("R5 L3 invalid fault flag", fault, 1);
  endtask

  task automatic tBusyIgnore();
    int r0, n;
    setupTables(32'h0012_3462);
    memLat = 2;
    r0 = rdCount;
    @(negedge clk);
    vaddr = 32'h0104_5ABC; ctxNum = 8'd1; mmuEnable = 1'b1; isWrite = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R9 busy after start", busy, 1);
    @(negedge clk);
    vaddr = 32'h02AB_CDEF; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R9 busy mid walk", busy, 1);
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R9 busy low at done", busy, 0);
    chk("R9 ignored start pa", physAddr, 36'h0_0123_4ABC);
    chk("R9 read count", rdCount - r0, 4);
    @(negedge clk);
    chk("R9 no second walk", busy, 0);
  endtask

  task automatic tResetMid();
    setupTables(32'h0012_3402);
    memLat = 3;
    @(negedge clk);
    vaddr = 32'h0104_5ABC; ctxNum = 8'd1; mmuEnable = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy cleared", busy, 0);
    chk("R10 memReqValid cleared", memReqValid, 0);
    chk("R10 done cleared", done, 0);
    memLat = 0;
    walk(32'h0108_1234, 8'd1, 1'b1, 1'b0);
    chk("R10 walk after reset", physAddr, 36'h0_0050_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tBypass();
    t4kRead();
    t4kWriteMod();
    tNoWb();
    tBigPages();
    tFaults();
    tBusyIgnore();
    tResetMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule